// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the part of a host-side SMBus controller that software sees. It sits behind a byte-wide register port with eight offsets. It holds the status, control, host command, target address and two data bytes. It also holds a 32-entry byte buffer for block transfers. Software reaches that buffer through a single data window whose internal pointer advances on every access.

Software fills in the operands and then writes the control register with the start bit set. The block sends a one-cycle start request and the operand values to a separate protocol sequencer. Status then reads as busy until the sequencer returns a completion code. The sequencer returns read data through dedicated strobes for the two data bytes. It also has its own indexed port into the buffer, which leaves the software pointer untouched. A kill bit in the control register cancels a command that is in flight and reports a failure code. Software clears status flags by writing 1 to them.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register, the buffer, the buffer pointer and the read data output are 0, and no start or abort pulse is present.
- R2: A read with `bus_sel`=1 and `bus_we`=0 returns on `bus_rdata` on the next clock. Offset 0 is status, 2 is control, 3 is host command, 4 is target address, 5 is data0, 6 is data1 and 7 is the buffer window. Offset 1 reads 0, and writes to it have no effect.
- R3: Writes to offsets 3 to 6 store the byte. The stored command, address, data0, data1 and control values appear unchanged on `seq_cmd`, `seq_addr`, `seq_data0`, `seq_data1` and `seq_ctl`.
- R4: A control write stores only the bits of mask 0x1f, or 0x3f when `WIDE_CTL`=1. Bit 6 (start) and bit 7 are never stored.
- R5: A control write with bit 6 set raises `seq_start` for exactly one cycle, in the cycle after the write. From that cycle, status reads exactly 0x01 (busy) until the command ends.
- R6: A `seq_done` pulse while a command is pending replaces status with `seq_code` and ends the command. A `seq_done` pulse while idle leaves status unchanged.
- R7: A control write with bit 1 (kill) set and bit 6 clear, while a command is pending, sets status to exactly 0x10, ends the command and pulses `seq_abort` for one cycle. A later `seq_done` for that command is then ignored. A kill while idle changes nothing.
- R8: A status write clears each of status bits 1 to 4 (masks 0x02, 0x04, 0x08, 0x10) that is written as 1. It leaves bits 0 and 5 to 7, and every bit written as 0, unchanged.
- R9: Each read or write at offset 7 accesses the buffer entry at the software pointer and then advances the pointer. The pointer wraps from DEPTH-1 back to 0.
- R10: Reading the control register (offset 2) resets the software buffer pointer to 0.
- R11: The sequencer buffer port reads the entry at `seq_buf_idx` without delay and writes it on `seq_buf_we`. Neither action moves the software pointer.
- R12: `seq_d0_we` and `seq_d1_we` load data0 and data1 from `seq_d0` and `seq_d1`. Software sees the new values at offsets 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| seq_start | output | 1 | One-cycle start request |
| seq_abort | output | 1 | One-cycle cancel of the pending command |
| seq_ctl | output | 8 | Stored control value |
| seq_cmd | output | 8 | Host command byte |
| seq_addr | output | 8 | Target address byte |
| seq_data0 | output | 8 | Data0 byte |
| seq_data1 | output | 8 | Data1 byte |
| seq_done | input | 1 | Completion pulse from the sequencer |
| seq_code | input | 8 | Completion status code |
| seq_d0_we | input | 1 | Load data0 from the sequencer |
| seq_d0 | input | 8 | Data0 read value |
| seq_d1_we | input | 1 | Load data1 from the sequencer |
| seq_d1 | input | 8 | Data1 read value |
| seq_buf_idx | input | IDX_W | Sequencer buffer index |
| seq_buf_we | input | 1 | Sequencer buffer write enable |
| seq_buf_wdata | input | 8 | Sequencer buffer write data |
| seq_buf_rdata | output | 8 | Buffer entry at `seq_buf_idx` |

## Verification
The assertions assume that `seq_done` arrives only as a single-cycle pulse. They assume no sequencer strobe lands in the same cycle as a software write to the same register or buffer entry, because in that case the sequencer wins. They also assume `bus_addr` and `bus_we` are known whenever `bus_sel` is high. The stimulus issues a single operation per cycle group, whether a bus access, a completion pulse or a sequencer write, and never two at once. Random control writes set the start and kill bits freely, so busy, kill and completion interleave in every order while each event stays separate.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int DW = 8;

  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_CMD  = 3'd3;
  localparam logic [2:0] OFS_ADR  = 3'd4;
  localparam logic [2:0] OFS_D0   = 3'd5;
  localparam logic [2:0] OFS_D1   = 3'd6;
  localparam logic [2:0] OFS_BLK  = 3'd7;

  localparam logic [DW-1:0] ST_BUSY     = 8'h01;
  localparam logic [DW-1:0] ST_FAIL     = 8'h10;
  localparam logic [DW-1:0] ST_W1C_MASK = 8'h1e;

  localparam int CTL_KILL_BIT  = 1;
  localparam int CTL_START_BIT = 6;
endpackage

// File: rtl/smb_host_status.sv
module smb_host_status
  import smb_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_wr,
  input  logic [DW-1:0] st_wdata,
  input  logic          start_req,
  input  logic          kill_req,
  input  logic          done_in,
  input  logic [DW-1:0] done_code,
  output logic [DW-1:0] status,
  output logic          pending,
  output logic          abort_pulse
);
  logic [DW-1:0] stat_q, stat_d;
  logic          pend_q, pend_d;
  logic          abort_q, abort_d;

  always_comb begin
    stat_d  = stat_q;
    pend_d  = pend_q;
    abort_d = 1'b0;
    if (st_wr) stat_d = stat_q & ~(st_wdata & ST_W1C_MASK);
    if (done_in && pend_q) begin
      stat_d = done_code;
      pend_d = 1'b0;
    end
    if (kill_req && pend_q && !start_req) begin
      stat_d  = ST_FAIL;
      pend_d  = 1'b0;
      abort_d = 1'b1;
    end
    if (start_req) begin
      stat_d = ST_BUSY;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      pend_q  <= pend_d;
      abort_q <= abort_d;
    end
  end

  assign status      = stat_q;
  assign pending     = pend_q;
  assign abort_pulse = abort_q;

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !pend_q) |=> (stat_q == ($past(stat_q) & ~($past(st_wdata) & ST_W1C_MASK))));
  // R6
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_in && pend_q && !kill_req && !start_req) |=> (stat_q == $past(done_code) && !pend_q));
  // R7
  kill_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_req && pend_q && !start_req) |=> (stat_q == ST_FAIL && abort_q && !pend_q));
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (stat_q == ST_BUSY));
endmodule

// File: rtl/smb_host_cfg.sv
module smb_host_cfg
  import smb_host_pkg::*;
#(
  parameter bit WIDE_CTL = 1'b0,
  localparam logic [DW-1:0] CTL_MASK = WIDE_CTL ? 8'h3f : 8'h1f
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_ofs,
  input  logic [DW-1:0] wr_data,
  input  logic          d0_load,
  input  logic [DW-1:0] d0_val,
  input  logic          d1_load,
  input  logic [DW-1:0] d1_val,
  output logic [DW-1:0] ctl,
  output logic [DW-1:0] cmd,
  output logic [DW-1:0] adr,
  output logic [DW-1:0] d0,
  output logic [DW-1:0] d1
);
  logic [DW-1:0] ctl_q, cmd_q, adr_q, d0_q, d1_q;
  logic [DW-1:0] ctl_d, cmd_d, adr_d, d0_d, d1_d;
  logic          ctl_en, cmd_en, adr_en, d0_en, d1_en;

  always_comb begin
    ctl_en = wr_en && (wr_ofs == OFS_CTL);
    cmd_en = wr_en && (wr_ofs == OFS_CMD);
    adr_en = wr_en && (wr_ofs == OFS_ADR);
    d0_en  = d0_load || (wr_en && (wr_ofs == OFS_D0));
    d1_en  = d1_load || (wr_en && (wr_ofs == OFS_D1));
    ctl_d  = wr_data & CTL_MASK;
    cmd_d  = wr_data;
    adr_d  = wr_data;
    d0_d   = d0_load ? d0_val : wr_data;
    d1_d   = d1_load ? d1_val : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmd_q <= '0;
      adr_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (cmd_en) cmd_q <= cmd_d;
      if (adr_en) adr_q <= adr_d;
      if (d0_en)  d0_q  <= d0_d;
      if (d1_en)  d1_q  <= d1_d;
    end
  end

  assign ctl = ctl_q;
  assign cmd = cmd_q;
  assign adr = adr_q;
  assign d0  = d0_q;
  assign d1  = d1_q;

  // R4
  ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == OFS_CTL) |=> ((ctl_q & ~CTL_MASK) == '0 && !ctl_q[CTL_START_BIT]));
  // R12
  seq_d0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d0_load |=> (d0_q == $past(d0_val)));
endmodule

// File: rtl/smb_host_blkbuf.sv
module smb_host_blkbuf
  import smb_host_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_acc,
  input  logic             sw_we,
  input  logic [DW-1:0]    sw_wdata,
  input  logic             idx_clr,
  output logic [DW-1:0]    sw_rdata,
  input  logic [IDX_W-1:0] sq_idx,
  input  logic             sq_we,
  input  logic [DW-1:0]    sq_wdata,
  output logic [DW-1:0]    sq_rdata
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (idx_clr)     idx_d = '0;
    else if (sw_acc) idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_sq, ent_sw;
    assign ent_sq = sq_we && (sq_idx == IDX_W'(g));
    assign ent_sw = sw_acc && sw_we && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= '0;
      else if (ent_sq) mem_q[g] <= sq_wdata;
      else if (ent_sw) mem_q[g] <= sw_wdata;
    end
  end

  assign sw_rdata = mem_q[idx_q];
  assign sq_rdata = mem_q[sq_idx];

  // R9
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_acc && !idx_clr && idx_q == IDX_LAST) |=> (idx_q == '0));
  // R10
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> (idx_q == '0));
  // R11
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_acc && !idx_clr) |=> $stable(idx_q));
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter bit WIDE_CTL = 1'b0,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             seq_start,
  output logic             seq_abort,
  output logic [DW-1:0]    seq_ctl,
  output logic [DW-1:0]    seq_cmd,
  output logic [DW-1:0]    seq_addr,
  output logic [DW-1:0]    seq_data0,
  output logic [DW-1:0]    seq_data1,
  input  logic             seq_done,
  input  logic [DW-1:0]    seq_code,
  input  logic             seq_d0_we,
  input  logic [DW-1:0]    seq_d0,
  input  logic             seq_d1_we,
  input  logic [DW-1:0]    seq_d1,
  input  logic [IDX_W-1:0] seq_buf_idx,
  input  logic             seq_buf_we,
  input  logic [DW-1:0]    seq_buf_wdata,
  output logic [DW-1:0]    seq_buf_rdata
);
  logic          wr_en, rd_en, ctl_wr, ctl_rd, st_wr, blk_acc;
  logic          start_req, kill_req;
  logic          start_q;
  logic [DW-1:0] status, blk_rdata;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          pending;

  always_comb begin
    wr_en     = bus_sel && bus_we;
    rd_en     = bus_sel && !bus_we;
    ctl_wr    = wr_en && (bus_addr == OFS_CTL);
    ctl_rd    = rd_en && (bus_addr == OFS_CTL);
    st_wr     = wr_en && (bus_addr == OFS_STAT);
    blk_acc   = bus_sel && (bus_addr == OFS_BLK);
    start_req = ctl_wr && bus_wdata[CTL_START_BIT];
    kill_req  = ctl_wr && bus_wdata[CTL_KILL_BIT];
  end

  smb_host_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_wr      (st_wr),
    .st_wdata   (bus_wdata),
    .start_req  (start_req),
    .kill_req   (kill_req),
    .done_in    (seq_done),
    .done_code  (seq_code),
    .status     (status),
    .pending    (pending),
    .abort_pulse(seq_abort)
  );

  smb_host_cfg #(.WIDE_CTL(WIDE_CTL)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_ofs (bus_addr),
    .wr_data(bus_wdata),
    .d0_load(seq_d0_we),
    .d0_val (seq_d0),
    .d1_load(seq_d1_we),
    .d1_val (seq_d1),
    .ctl    (seq_ctl),
    .cmd    (seq_cmd),
    .adr    (seq_addr),
    .d0     (seq_data0),
    .d1     (seq_data1)
  );

  smb_host_blkbuf #(.DEPTH(DEPTH)) u_blk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_acc  (blk_acc),
    .sw_we   (bus_we),
    .sw_wdata(bus_wdata),
    .idx_clr (ctl_rd),
    .sw_rdata(blk_rdata),
    .sq_idx  (seq_buf_idx),
    .sq_we   (seq_buf_we),
    .sq_wdata(seq_buf_wdata),
    .sq_rdata(seq_buf_rdata)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_STAT: rdata_d = status;
      OFS_CTL:  rdata_d = seq_ctl;
      OFS_CMD:  rdata_d = seq_cmd;
      OFS_ADR:  rdata_d = seq_addr;
      OFS_D0:   rdata_d = seq_data0;
      OFS_D1:   rdata_d = seq_data1;
      OFS_BLK:  rdata_d = blk_rdata;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      start_q <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rdata_d;
      start_q <= start_req;
    end
  end

  assign bus_rdata = rdata_q;
  assign seq_start = start_q;

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (pending && status == ST_BUSY));
  // R2
  cmd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == OFS_CMD) |=> (bus_rdata == $past(seq_cmd)));
  // R2
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == 3'd1) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_smb_host_regs.sv
module sim_smb_host_regs;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       seq_start, seq_abort;
  logic [7:0] seq_ctl, seq_cmd, seq_addr, seq_data0, seq_data1;
  logic       seq_done = 1'b0;
  logic [7:0] seq_code = '0;
  logic       seq_d0_we = 1'b0, seq_d1_we = 1'b0;
  logic [7:0] seq_d0 = '0, seq_d1 = '0;
  logic [4:0] seq_buf_idx = '0;
  logic       seq_buf_we = 1'b0;
  logic [7:0] seq_buf_wdata = '0, seq_buf_rdata;

  always #2 clk = ~clk;

  smb_host_regs #(.DEPTH(DEPTH)) u0 (.*);

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [7:0] m_stat, m_ctl, m_cmd, m_adr, m_d0, m_d1;
  logic [7:0] m_buf [DEPTH];
  int         m_idx;
  bit         m_pend;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_stat;
      3'd2: return m_ctl;
      3'd3: return m_cmd;
      3'd4: return m_adr;
      3'd5: return m_d0;
      3'd6: return m_d1;
      3'd7: return m_buf[m_idx];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: m_stat = m_stat & ~(d & 8'h1e);
      3'd2: begin
        m_ctl = d & 8'h1f;
        if (d[6]) begin m_pend = 1; m_stat = 8'h01; end
        else if (d[1] && m_pend) begin m_pend = 0; m_stat = 8'h10; end
      end
      3'd3: m_cmd = d;
      3'd4: m_adr = d;
      3'd5: m_d0 = d;
      3'd6: m_d1 = d;
      3'd7: begin m_buf[m_idx] = d; m_idx = (m_idx + 1) % DEPTH; end
      default: ;
    endcase
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    model_wr(a, d);
  endtask

  task automatic bus_rd(input logic [2:0] a, input string tag);
    logic [7:0] e;
    e = exp_read(a);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(bus_rdata == e, tag, bus_rdata, e);
    if (a == 3'd7) m_idx = (m_idx + 1) % DEPTH;
    if (a == 3'd2) m_idx = 0;
  endtask

  task automatic done_pulse(input logic [7:0] c);
    @(negedge clk);
    seq_done = 1; seq_code = c;
    @(negedge clk);
    seq_done = 0;
    if (m_pend) begin m_stat = c; m_pend = 0; end
  endtask

  task automatic start_cmd(input string tag);
    bus_wr(3'd2, 8'h40 | 8'h0c);
    chk(seq_start == 1'b1, tag, seq_start, 1);
    @(negedge clk);
    chk(seq_start == 1'b0, tag, seq_start, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    m_stat = 0; m_ctl = 0; m_cmd = 0; m_adr = 0; m_d0 = 0; m_d1 = 0;
    m_idx = 0; m_pend = 0;
    for (int i = 0; i < DEPTH; i++) m_buf[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    chk(seq_start == 0 && seq_abort == 0, "R1 pulses", {seq_start, seq_abort}, 0);
    chk(seq_buf_rdata == 0, "R1 buffer", seq_buf_rdata, 0);
    for (int a = 0; a < 8; a++) bus_rd(3'(a), "R1 reg read");

    // R2 R3 store and read back, hole offset
    bus_wr(3'd3, 8'hA5); bus_wr(3'd4, 8'h5B); bus_wr(3'd5, 8'h11); bus_wr(3'd6, 8'hEE);
    bus_wr(3'd1, 8'hFF);
    bus_rd(3'd1, "R2 hole");
    bus_rd(3'd3, "R2 cmd"); bus_rd(3'd6, "R2 d1");
    chk(seq_cmd == 8'hA5 && seq_addr == 8'h5B, "R3 outputs", {seq_cmd, seq_addr}, 16'hA55B);
    chk(seq_data0 == 8'h11 && seq_data1 == 8'hEE, "R3 data outputs", {seq_data0, seq_data1}, 16'h11EE);

    // R4 mask, kill while idle is no-op (R7)
    bus_wr(3'd2, 8'hBF);
    bus_rd(3'd2, "R4 ctl mask");
    chk(seq_abort == 0, "R7 idle kill abort", seq_abort, 0);
    bus_rd(3'd0, "R7 idle kill status");

    // R5 R6 start then completion
    start_cmd("R5 start pulse");
    bus_rd(3'd0, "R5 busy");
    bus_wr(3'd0, 8'hff);
    bus_rd(3'd0, "R8 busy not clearable");
    done_pulse(8'hE6);
    bus_rd(3'd0, "R6 completion code");
    done_pulse(8'h02);
    bus_rd(3'd0, "R6 idle done ignored");
    // R8 clear bits 1..4 only
    bus_wr(3'd0, 8'h14);
    bus_rd(3'd0, "R8 w1c");

    // R7 kill while pending
    start_cmd("R5 start pulse 2");
    bus_wr(3'd2, 8'h02);
    chk(seq_abort == 1, "R7 abort pulse", seq_abort, 1);
    bus_rd(3'd0, "R7 fail status");
    done_pulse(8'h02);
    bus_rd(3'd0, "R7 late done ignored");

    // R9 R10 wrap
    bus_rd(3'd2, "R10 ctl read");
    for (int i = 0; i <= DEPTH; i++) bus_wr(3'd7, 8'(8'h30 + i));
    bus_rd(3'd2, "R10 index reset");
    bus_rd(3'd7, "R9 wrapped entry 0");
    bus_rd(3'd7, "R9 entry 1");

    // R11 R12 sequencer side
    @(negedge clk);
    seq_buf_idx = 5'd9; seq_buf_we = 1; seq_buf_wdata = 8'h77;
    @(negedge clk);
    seq_buf_we = 0; m_buf[9] = 8'h77;
    #1 chk(seq_buf_rdata == 8'h77, "R11 seq read", seq_buf_rdata, 8'h77);
    bus_rd(3'd7, "R11 sw index untouched");
    @(negedge clk);
    seq_d0_we = 1; seq_d0 = 8'h3C; seq_d1_we = 1; seq_d1 = 8'hC3;
    @(negedge clk);
    seq_d0_we = 0; seq_d1_we = 0; m_d0 = 8'h3C; m_d1 = 8'hC3;
    bus_rd(3'd5, "R12 d0"); bus_rd(3'd6, "R12 d1");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) begin
        logic [2:0] a; logic [7:0] d;
        a = 3'($urandom_range(0, 7)); d = 8'($urandom);
        if (a == 3'd2 && $urandom_range(0, 2) != 0) d[6] = 1'b0;
        bus_wr(a, d);
      end else if (op < 7) begin
        bus_rd(3'($urandom_range(0, 7)), "R2 R9 random read");
      end else if (op == 7) begin
        done_pulse(8'($urandom));
      end else if (op == 8) begin
        logic [4:0] ix; logic [7:0] v;
        ix = 5'($urandom); v = 8'($urandom);
        @(negedge clk);
        seq_buf_idx = ix; seq_buf_we = 1; seq_buf_wdata = v;
        @(negedge clk);
        seq_buf_we = 0; m_buf[ix] = v;
        seq_buf_idx = 5'($urandom);
        #1 chk(seq_buf_rdata == m_buf[seq_buf_idx], "R11 random seq read", seq_buf_rdata, m_buf[seq_buf_idx]);
      end else begin
        logic [7:0] v;
        v = 8'($urandom);
        @(negedge clk);
        seq_d1_we = 1; seq_d1 = v;
        @(negedge clk);
        seq_d1_we = 0; m_d1 = v;
        chk(seq_data1 == v && seq_ctl == m_ctl, "R12 R3 random outputs", {seq_data1, seq_ctl}, {v, m_ctl});
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule